// File: doc/BRIEF.md
# Memory Wait-State Timing Calculator

This block stores one delay-configuration word for each of several external memory regions, plus one word of shared delay values that every region can draw on. From these words it works out how many cycles a byte, a halfword and a word access to each region take. The arithmetic builds a first-access time and a sequential-access time. It adds shared delay fields when a region enables them, applies a small-value increment and lower clamps, and then scales the result by the region's data-bus width.

Software-side logic writes and reads the words through a single address port. Each write merges through a bit mask, so protected bits keep their stored value. When a write actually changes a stored word, the counts for every region are recomputed and stored. A region-select input then chooses which region's three counts appear on the outputs. The bus sequencer that consumes these counts sits outside this block.

Top module: `mwt_timing_calc`

## Requirements
- R1: After reset, the words read back at slot 1 = 0x00003022, slot 2 = 0x0013243F, slot 3 = 0x200931E1 and the shared-delay slot (slot 8, the index equal to the region count) = 0x00031125. Reads use `reg_addr`, and `rd_data` is combinational.
- R2: After reset, the counts (byte/half/word) are 5/5/9 for region 1, 6/12/24 for region 2 and 20/20/40 for region 3.
- R3: A write to a region slot changes only the bits in mask 0xAF1FFFFF. A write to slot 8 changes only the bits in mask 0x0003FFFF. All other bits keep their stored value.
- R4: Region word bit 8 enables shared field c0 (slot 8 bits 3:0), which adds c0-1 to both the first and sequential times. Bit 10 enables c2 (bits 11:8), which adds c2 to both.
- R5: Region word bit 11 sets a minimum equal to c3 (slot 8 bits 15:12); otherwise the minimum is 0. The first time is clamped to at least minimum+6 and the sequential time to at least minimum+2. The byte count is therefore never below 5.
- R6: If the first time is below 6 after the shared-field additions, it is incremented once. Then access+2 (access = region bits 7:4) is added to both times.
- R7: With region bit 12 set (16-bit bus), half = first and word = first+seq. With bit 12 clear, half = first+seq and word = first+3*seq. Byte = first in both cases.
- R8: Each output count equals the computed cycle value minus 1, floored at 0.
- R9: The new counts appear on the outputs at the first clock edge that stores a changing write. A write that leaves the stored word unchanged leaves all counts unchanged.
- R10: Writes to addresses above slot 8 are ignored, and reads there return 0.
- R11: `region_sel` chooses the region whose counts drive the outputs, combinationally and with no clock delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W (4) | Slot index for read and write |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data, merged through the slot's mask |
| rd_data | output | 32 | Stored word at `reg_addr`, 0 above slot 8 |
| region_sel | input | SEL_W (3) | Region whose counts are output |
| byte_cycles | output | CNT_W (8) | Byte access count of the selected region |
| half_cycles | output | CNT_W (8) | Halfword access count of the selected region |
| word_cycles | output | CNT_W (8) | Word access count of the selected region |

## Verification
Two things can fall in the same cycle: a register write that changes a region's counts, and a change of `region_sel` to that same region. The bench drives both at one falling edge. It then expects the outputs at the next falling edge to show the freshly computed values for the newly selected region, with no stale mix. It also writes the shared-delay slot while a different region is selected. That write must move every region's counts in the same edge, so the bench compares each region against its model afterwards.

// File: rtl/mwt_pkg.sv
package mwt_pkg;

    // shared-delay slot masks and reset word
    localparam logic [31:0] REGION_WMASK = 32'hAF1F_FFFF;
    localparam logic [31:0] COMMON_WMASK = 32'h0003_FFFF;
    localparam logic [31:0] COMMON_RST   = 32'h0003_1125;

    typedef struct packed {
        logic [15:0] b;
        logic [15:0] h;
        logic [15:0] w;
    } mwt_times_t;

    function automatic logic [31:0] region_reset(input int idx);
        case (idx)
            1:       return 32'h0000_3022;
            3:       return 32'h2009_31E1;
            4:       return 32'h0002_0843;
            5:       return 32'h0007_0777;
            default: return 32'h0013_243F;
        endcase
    endfunction

    function automatic mwt_times_t calc_times(input logic [31:0] rgn, input logic [31:0] com);
        int first;
        int seq;
        int floor_v;
        int cb;
        int ch;
        int cw;
        mwt_times_t t;
        first   = 0;
        seq     = 0;
        floor_v = 0;
        if (rgn[8]) begin
            first = first + int'(com[3:0]) - 1;
            seq   = seq + int'(com[3:0]) - 1;
        end
        if (rgn[10]) begin
            first = first + int'(com[11:8]);
            seq   = seq + int'(com[11:8]);
        end
        if (rgn[11]) floor_v = int'(com[15:12]);
        if (first < 6) first = first + 1;
        first = first + int'(rgn[7:4]) + 2;
        seq   = seq + int'(rgn[7:4]) + 2;
        if (first < floor_v + 6) first = floor_v + 6;
        if (seq < floor_v + 2) seq = floor_v + 2;
        cb = first;
        ch = rgn[12] ? first : first + seq;
        cw = rgn[12] ? first + seq : first + 3 * seq;
        t.b = (cb > 0) ? 16'(cb - 1) : 16'd0;
        t.h = (ch > 0) ? 16'(ch - 1) : 16'd0;
        t.w = (cw > 0) ? 16'(cw - 1) : 16'd0;
        return t;
    endfunction

endpackage

// File: rtl/mwt_regfile.sv
module mwt_regfile
    import mwt_pkg::*;
#(
    parameter  int NUM_REGIONS = 8,
    localparam int NUM_SLOTS   = NUM_REGIONS + 1,
    localparam int ADDR_W      = $clog2(NUM_SLOTS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             reg_addr,
    input  logic                          wr_en,
    input  logic [31:0]                   wr_data,
    output logic [NUM_SLOTS-1:0][31:0]    regs_q,
    output logic [NUM_SLOTS-1:0][31:0]    regs_d,
    output logic                          changed_d
);

    typedef struct packed {
        logic [NUM_SLOTS-1:0][31:0] regs;
    } rf_t;

    rf_t         st_d;
    rf_t         st_q;
    logic [31:0] mask_w;
    logic [31:0] old_w;
    logic [31:0] new_w;
    logic        in_range;

    assign in_range = int'(reg_addr) < NUM_SLOTS;

    always_comb begin
        st_d      = st_q;
        changed_d = 1'b0;
        mask_w    = (int'(reg_addr) == NUM_REGIONS) ? COMMON_WMASK : REGION_WMASK;
        old_w     = in_range ? st_q.regs[reg_addr] : 32'd0;
        new_w     = (old_w & ~mask_w) | (wr_data & mask_w);
        if (wr_en && in_range && (new_w != old_w)) begin
            st_d.regs[reg_addr] = new_w;
            changed_d           = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                st_q.regs[i] <= (i == NUM_REGIONS) ? COMMON_RST : region_reset(i);
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign regs_q = st_q.regs;
    assign regs_d = st_d.regs;

endmodule

// File: rtl/mwt_calc.sv
module mwt_calc
    import mwt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic [31:0]      rgn_word,
    input  logic [31:0]      com_word,
    output logic [CNT_W-1:0] byte_cnt,
    output logic [CNT_W-1:0] half_cnt,
    output logic [CNT_W-1:0] word_cnt
);

    mwt_times_t t;

    assign t        = calc_times(rgn_word, com_word);
    assign byte_cnt = t.b[CNT_W-1:0];
    assign half_cnt = t.h[CNT_W-1:0];
    assign word_cnt = t.w[CNT_W-1:0];

endmodule

// File: rtl/mwt_timing_calc.sv
module mwt_timing_calc
    import mwt_pkg::*;
#(
    parameter  int NUM_REGIONS = 8,
    parameter  int CNT_W       = 8,
    localparam int NUM_SLOTS   = NUM_REGIONS + 1,
    localparam int ADDR_W      = $clog2(NUM_SLOTS),
    localparam int SEL_W       = $clog2(NUM_REGIONS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    output logic [31:0]       rd_data,
    input  logic [SEL_W-1:0]  region_sel,
    output logic [CNT_W-1:0]  byte_cycles,
    output logic [CNT_W-1:0]  half_cycles,
    output logic [CNT_W-1:0]  word_cycles
);

    typedef struct packed {
        logic [NUM_REGIONS-1:0][CNT_W-1:0] b;
        logic [NUM_REGIONS-1:0][CNT_W-1:0] h;
        logic [NUM_REGIONS-1:0][CNT_W-1:0] w;
    } cnt_t;

    logic [NUM_SLOTS-1:0][31:0]        regs_q;
    logic [NUM_SLOTS-1:0][31:0]        regs_d;
    logic                              changed_d;
    logic [NUM_REGIONS-1:0][CNT_W-1:0] calc_b;
    logic [NUM_REGIONS-1:0][CNT_W-1:0] calc_h;
    logic [NUM_REGIONS-1:0][CNT_W-1:0] calc_w;
    cnt_t                              rst_cnt;
    cnt_t                              cnt_d;
    cnt_t                              cnt_q;

    mwt_regfile #(.NUM_REGIONS(NUM_REGIONS)) u_regfile (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .regs_q    (regs_q),
        .regs_d    (regs_d),
        .changed_d (changed_d)
    );

    // one calculator per region, fed from the next-state words
    for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
        mwt_times_t rst_t;

        mwt_calc #(.CNT_W(CNT_W)) u_calc (
            .rgn_word (regs_d[r]),
            .com_word (regs_d[NUM_REGIONS]),
            .byte_cnt (calc_b[r]),
            .half_cnt (calc_h[r]),
            .word_cnt (calc_w[r])
        );

        assign rst_t        = calc_times(region_reset(r), COMMON_RST);
        assign rst_cnt.b[r] = rst_t.b[CNT_W-1:0];
        assign rst_cnt.h[r] = rst_t.h[CNT_W-1:0];
        assign rst_cnt.w[r] = rst_t.w[CNT_W-1:0];
    end

    always_comb begin
        cnt_d = cnt_q;
        if (changed_d) begin
            cnt_d.b = calc_b;
            cnt_d.h = calc_h;
            cnt_d.w = calc_w;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= rst_cnt;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign rd_data     = (int'(reg_addr) < NUM_SLOTS) ? regs_q[reg_addr] : 32'd0;
    assign byte_cycles = cnt_q.b[region_sel];
    assign half_cycles = cnt_q.h[region_sel];
    assign word_cycles = cnt_q.w[region_sel];

endmodule

// File: rtl/mwt_timing_calc_chk.sv
module mwt_timing_calc_chk
    import mwt_pkg::*;
#(
    parameter  int NUM_REGIONS = 8,
    parameter  int CNT_W       = 8,
    localparam int NUM_SLOTS   = NUM_REGIONS + 1,
    localparam int ADDR_W      = $clog2(NUM_SLOTS),
    localparam int SEL_W       = $clog2(NUM_REGIONS)
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [ADDR_W-1:0]          reg_addr,
    input logic                       wr_en,
    input logic [SEL_W-1:0]           region_sel,
    input logic [CNT_W-1:0]           byte_cycles,
    input logic [CNT_W-1:0]           half_cycles,
    input logic [CNT_W-1:0]           word_cycles,
    input logic [NUM_SLOTS-1:0][31:0] regs_q
);

    assert_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_cycles <= half_cycles) && (half_cycles <= word_cycles));

    assert_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
        byte_cycles >= CNT_W'(5));

    assert_wide_R7: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q[region_sel][12] |-> (half_cycles == byte_cycles));

    assert_narrow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !regs_q[region_sel][12] |-> (half_cycles > byte_cycles));

    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_en) && $stable(region_sel)) |->
        ($stable(byte_cycles) && $stable(half_cycles) && $stable(word_cycles)));

    assert_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && reg_addr == ADDR_W'(NUM_REGIONS)) |=>
        ((regs_q[NUM_REGIONS] & ~COMMON_WMASK) == ($past(regs_q[NUM_REGIONS]) & ~COMMON_WMASK)));

endmodule

bind mwt_timing_calc mwt_timing_calc_chk #(
    .NUM_REGIONS (NUM_REGIONS),
    .CNT_W       (CNT_W)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_addr    (reg_addr),
    .wr_en       (wr_en),
    .region_sel  (region_sel),
    .byte_cycles (byte_cycles),
    .half_cycles (half_cycles),
    .word_cycles (word_cycles),
    .regs_q      (regs_q)
);

// File: tb/test_mwt_timing_calc.sv
module test_mwt_timing_calc;

    localparam int NR = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [2:0]  region_sel = '0;
    logic [7:0]  byte_cycles;
    logic [7:0]  half_cycles;
    logic [7:0]  word_cycles;

    int          n_chk = 0;
    int          n_fail = 0;
    logic [31:0] shadow [0:NR];
    logic [31:0] seed = 32'h1234_5678;

    always #4 clk = ~clk;

    mwt_timing_calc i_mwt_timing_calc (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_addr    (reg_addr),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .rd_data     (rd_data),
        .region_sel  (region_sel),
        .byte_cycles (byte_cycles),
        .half_cycles (half_cycles),
        .word_cycles (word_cycles)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d (0x%08h) expected %0d (0x%08h)", req, act, act, exp, exp);
        end
    endtask

    function automatic void model(input logic [31:0] rg, input logic [31:0] cm,
                                  output int b, output int h, output int w);
        int f;
        int s;
        int m;
        f = 0; s = 0; m = 0;
        if (rg[8])  begin f = f + int'(cm[3:0]) - 1; s = s + int'(cm[3:0]) - 1; end
        if (rg[10]) begin f = f + int'(cm[11:8]);    s = s + int'(cm[11:8]);    end
        if (rg[11]) m = int'(cm[15:12]);
        if (f < 6) f = f + 1;
        f = f + int'(rg[7:4]) + 2;
        s = s + int'(rg[7:4]) + 2;
        if (f < m + 6) f = m + 6;
        if (s < m + 2) s = m + 2;
        b = f - 1;
        h = (rg[12] ? f : f + s) - 1;
        w = (rg[12] ? f + s : f + 3 * s) - 1;
        if (b < 0) b = 0;
        if (h < 0) h = 0;
        if (w < 0) w = 0;
    endfunction

    function automatic logic [31:0] next_rand();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    task automatic write_reg(input int a, input logic [31:0] d);
        logic [31:0] mk;
        @(negedge clk);
        reg_addr = 4'(a);
        wr_data  = d;
        wr_en    = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        if (a <= NR) begin
            mk = (a == NR) ? 32'h0003_FFFF : 32'hAF1F_FFFF;
            shadow[a] = (shadow[a] & ~mk) | (d & mk);
        end
    endtask

    task automatic check_region(input int r, input string req);
        int eb;
        int eh;
        int ew;
        region_sel = 3'(r);
        #1;
        model(shadow[r], shadow[NR], eb, eh, ew);
        chk({req, " byte"}, int'(byte_cycles), eb);
        chk({req, " half"}, int'(half_cycles), eh);
        chk({req, " word"}, int'(word_cycles), ew);
    endtask

    task automatic read_chk(input int a, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_addr = 4'(a);
        #1;
        chk(req, int'(rd_data), int'(exp));
    endtask

    task automatic t_reset();
        read_chk(1, 32'h0000_3022, "R1 slot1");
        read_chk(2, 32'h0013_243F, "R1 slot2");
        read_chk(3, 32'h2009_31E1, "R1 slot3");
        read_chk(8, 32'h0003_1125, "R1 common");
        region_sel = 3'd1; #1;
        chk("R2 r1 byte", int'(byte_cycles), 5);
        chk("R2 r1 half", int'(half_cycles), 5);
        chk("R2 r1 word", int'(word_cycles), 9);
        region_sel = 3'd2; #1;
        chk("R2 r2 byte", int'(byte_cycles), 6);
        chk("R2 r2 half", int'(half_cycles), 12);
        chk("R2 r2 word", int'(word_cycles), 24);
        region_sel = 3'd3; #1;
        chk("R2 r3 byte", int'(byte_cycles), 20);
        chk("R2 r3 half", int'(half_cycles), 20);
        chk("R2 r3 word", int'(word_cycles), 40);
    endtask

    task automatic t_mask();
        write_reg(8, 32'hFFFF_FFFF);
        read_chk(8, 32'h0003_FFFF, "R3 common mask");
        write_reg(0, 32'hFFFF_FFFF);
        read_chk(0, 32'hAF1F_FFFF, "R3 region mask");
        write_reg(3, 32'h0000_0000);
        read_chk(3, 32'h0000_0000, "R3 region clear");
        write_reg(8, 32'h0003_1125);
        check_region(0, "R3 after restore");
    endtask

    task automatic t_shared();
        // c0=0 gives first -1 before the increment, clamps decide
        write_reg(8, 32'h0000_0000);
        write_reg(4, 32'h0000_0100);
        check_region(4, "R4 c0 zero");
        region_sel = 3'd4; #1;
        chk("R5 clamp byte", int'(byte_cycles), 5);
        chk("R5 clamp word", int'(word_cycles), 11);
        // c0=6 and c0=7 land on the same first time
        write_reg(8, 32'h0000_0006);
        write_reg(4, 32'h0000_1100);
        check_region(4, "R6 c0 six");
        chk("R6 c0 six byte", int'(byte_cycles), 7);
        write_reg(8, 32'h0000_0007);
        check_region(4, "R6 c0 seven");
        chk("R6 c0 seven byte", int'(byte_cycles), 7);
        // c2 plus c3 minimum
        write_reg(8, 32'h0000_F300);
        write_reg(4, 32'h0000_0C20);
        check_region(4, "R5 c3 min");
        write_reg(4, 32'h0000_1C20);
        check_region(4, "R7 wide c3");
    endtask

    task automatic t_sweep();
        for (int i = 0; i < 40; i++) begin
            if (i % 5 == 0) write_reg(8, next_rand());
            write_reg(i % NR, next_rand());
            for (int r = 0; r < NR; r++) check_region(r, "R8 sweep");
        end
    endtask

    task automatic t_latency();
        int ob;
        int eb;
        int eh;
        int ew;
        write_reg(8, 32'h0003_1125);
        write_reg(5, 32'h0000_0000);
        region_sel = 3'd5; #1;
        ob = int'(byte_cycles);
        @(negedge clk);
        reg_addr = 4'd5;
        wr_data  = 32'h0000_10F0;
        wr_en    = 1'b1;
        #1;
        chk("R9 before edge", int'(byte_cycles), ob);
        @(negedge clk);
        wr_en = 1'b0;
        shadow[5] = 32'h0000_10F0;
        model(shadow[5], shadow[NR], eb, eh, ew);
        #1;
        chk("R9 one clock", int'(byte_cycles), eb);
        write_reg(5, 32'h5000_10F0);
        check_region(5, "R9 masked-only write");
    endtask

    task automatic t_oob();
        for (int a = 9; a < 16; a++) begin
            write_reg(a, 32'hFFFF_FFFF);
            read_chk(a, 32'h0, "R10 read zero");
        end
        for (int r = 0; r < NR; r++) check_region(r, "R10 counts kept");
        read_chk(8, shadow[8], "R10 common kept");
    endtask

    task automatic t_select();
        for (int r = 0; r < NR; r++) begin
            region_sel = 3'(r);
            #1;
            check_region(r, "R11 select");
        end
    endtask

    task automatic t_same_cycle();
        int eb;
        int eh;
        int ew;
        region_sel = 3'd0;
        @(negedge clk);
        region_sel = 3'd6;
        reg_addr   = 4'd6;
        wr_data    = 32'h0000_1D50;
        wr_en      = 1'b1;
        #1;
        model(shadow[6], shadow[NR], eb, eh, ew);
        chk("R11 before edge", int'(word_cycles), ew);
        @(negedge clk);
        wr_en = 1'b0;
        shadow[6] = 32'h0000_1D50;
        check_region(6, "R9 same cycle");
        region_sel = 3'd1;
        write_reg(8, 32'h0002_4A38);
        for (int r = 0; r < NR; r++) check_region(r, "R4 shared rewrite");
    endtask

    initial begin
        #(8 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < NR; i++) shadow[i] = 32'h0013_243F;
        shadow[1]  = 32'h0000_3022;
        shadow[3]  = 32'h2009_31E1;
        shadow[4]  = 32'h0002_0843;
        shadow[5]  = 32'h0007_0777;
        shadow[NR] = 32'h0003_1125;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mask();
        t_shared();
        t_latency();
        t_oob();
        t_select();
        t_same_cycle();
        t_sweep();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule